// File: doc/BRIEF.md
# TDI Signature Compactor with Masked Compare

This block reduces the serial data returned on the TDI line of a boundary-scan master to a 32-bit signature. It also checks captured words against expected words. A host sets up the compactor through 16-bit register writes. It writes the two halves of a starting value and the two halves of a feedback polynomial. A single load strobe then moves the staged starting value into the shift register, so a half-written value is never used. While compaction is enabled, every valid TDI bit advances the register by one Galois step. The host reads the signature back as a low and a high 16-bit word.

The compare path runs next to the compactor. The host starts a compare, which arms a pass flag. Every captured 32-bit word is then checked against its expected word. An optional mask leaves chosen bit positions out of the check. One unmasked mismatch drops the flag to fail, and the flag stays at fail until the next compare start. The flag comes out of reset at fail.

Top module: `tdi_sig_compactor`

## Requirements
- R1: After reset, the signature is 0, the staged seed and polynomial are 0, and the compare flag `cmp_pass` is 0 (fail).
- R2: A write with `cfg_sel`=0 stages seed bits 15:0 and `cfg_sel`=1 stages seed bits 31:16. Without a load strobe, these writes leave the signature unchanged.
- R3: When `seed_load` is high at a clock edge, the staged 32-bit seed is in the signature after that edge. This takes priority over a shift in the same cycle.
- R4: A write with `cfg_sel`=2 sets polynomial bits 15:0 and `cfg_sel`=3 sets bits 31:16. The new polynomial is used from the next shift on.
- R5: With `sig_en` and `tdi_valid` both high, each edge sets the signature S to (S<<1) XOR (P if S[31] XOR `tdi_bit` is 1, else 0), where P is the polynomial.
- R6: When `sig_en` or `tdi_valid` is low and no load is requested, the signature holds its value.
- R7: `sig_lo` shows signature bits 15:0 and `sig_hi` shows bits 31:16.
- R8: A `cmp_start` with no captured word in the same cycle sets `cmp_pass` to 1 at the next edge.
- R9: A captured word (`cap_valid`) that differs from `exp_word` in any bit that is not excluded sets `cmp_pass` to 0. The flag then stays 0 until the next `cmp_start`.
- R10: When `mask_en` is 1, bits where `mask_word` is 1 are excluded from the compare. When `mask_en` is 0, all 32 bits are compared.
- R11: A `cmp_start` in the same cycle as a captured word arms the compare and checks that word, so the flag becomes the pass result of that word alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 seed low, 1 seed high, 2 polynomial low, 3 polynomial high |
| cfg_wdata | input | 16 | Register write data |
| seed_load | input | 1 | Copy the staged seed into the signature |
| sig_en | input | 1 | Compaction enable |
| tdi_valid | input | 1 | A TDI bit is present this cycle |
| tdi_bit | input | 1 | Serial TDI data bit |
| sig_lo | output | 16 | Signature bits 15:0 |
| sig_hi | output | 16 | Signature bits 31:16 |
| cmp_start | input | 1 | Start a new compare (arm at pass) |
| cap_valid | input | 1 | A captured word is present this cycle |
| cap_word | input | 32 | Captured TDI word |
| exp_word | input | 32 | Expected word |
| mask_word | input | 32 | Exclusion mask (1 = ignore bit) |
| mask_en | input | 1 | Apply the mask |
| cmp_pass | output | 1 | Sticky compare result, 1 = pass |

## Verification
The assertions assume that the control strobes are never X after reset. They also assume that a load strobe and a shift may arrive together, with the load taking priority. The stimulus drives every input to a known level on the falling edge, and it holds reset low from time zero. The random phase mixes load strobes, register writes and shifts in the same cycles. Most captured words equal the expected word, so both the kept-pass and the forced-fail paths are exercised.

// File: rtl/sig_pkg.sv
// Package: shared widths and the Galois step used by the compactor.
// Assumes signature width is a multiple of the register word width.
package sig_pkg;
    localparam int SIG_W  = 32;
    localparam int WORD_W = 16;

    // One Galois step: shift left, fold polynomial when feedback is 1.
    function automatic logic [SIG_W-1:0] galois_step(
        input logic [SIG_W-1:0] cur,
        input logic [SIG_W-1:0] poly,
        input logic             din
    );
        logic fb;
        fb = cur[SIG_W-1] ^ din;
        return (cur << 1) ^ (fb ? poly : '0);
    endfunction
endpackage

// File: rtl/sig_cfg_regs.sv
// Staging registers for seed and polynomial, written one word at a time.
// Assumes sel values 0..NHALF-1 pick seed words, NHALF..2*NHALF-1 pick polynomial words.
module sig_cfg_regs #(
    parameter int SIG_W  = 32,
    parameter int WORD_W = 16,
    localparam int NHALF = SIG_W / WORD_W,
    localparam int SEL_W = $clog2(2 * NHALF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [SIG_W-1:0]  seed,
    output logic [SIG_W-1:0]  poly
);
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        // Stage seed word h.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seed[h*WORD_W +: WORD_W] <= '0;
            else if (wr && (sel == SEL_W'(h)))
                seed[h*WORD_W +: WORD_W] <= wdata;
        end
        // Hold polynomial word h.
        always_ff @(posedge clk) begin
            if (!rst_n)
                poly[h*WORD_W +: WORD_W] <= '0;
            else if (wr && (sel == SEL_W'(NHALF + h)))
                poly[h*WORD_W +: WORD_W] <= wdata;
        end
    end
endmodule

// File: rtl/sig_lfsr.sv
// Galois signature register fed by TDI bits; load strobe wins over shift.
// Assumes seed and poly are stable staging values from the config block.
module sig_lfsr #(
    parameter int SIG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SIG_W-1:0] seed,
    input  logic [SIG_W-1:0] poly,
    input  logic             step,
    input  logic             din,
    output logic [SIG_W-1:0] state
);
    import sig_pkg::galois_step;

    // Update the signature register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= '0;
        else if (load)
            state <= seed;
        else if (step)
            state <= galois_step(state, poly, din);
    end

    // R3
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state == $past(seed));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(state));
    // R5
    no_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && (state[SIG_W-1] == din)) |=> state == ($past(state) << 1));
endmodule

// File: rtl/sig_mask_cmp.sv
// Sticky masked compare of captured words against expected words.
// Assumes one captured word per cycle at most; start arms the flag at pass.
module sig_mask_cmp #(
    parameter int SIG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cap_valid,
    input  logic [SIG_W-1:0] cap_word,
    input  logic [SIG_W-1:0] exp_word,
    input  logic [SIG_W-1:0] mask_word,
    input  logic             mask_en,
    output logic             pass
);
    logic [SIG_W-1:0] ignore;
    logic             miss;

    // Work out the effective mask and the mismatch of this word.
    always_comb begin
        ignore = mask_en ? mask_word : '0;
        miss   = cap_valid && (|((cap_word ^ exp_word) & ~ignore));
    end

    // Sticky pass flag: armed by start, cleared by any mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pass <= 1'b0;
        else if (start)
            pass <= !miss;
        else if (miss)
            pass <= 1'b0;
    end

    // R9
    sticky_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !pass) |=> !pass);
    // R8
    arm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cap_valid) |=> pass);
    // R10
    masked_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && pass && cap_valid && mask_en && (&mask_word)) |=> pass);
endmodule

// File: rtl/tdi_sig_compactor.sv
// Top: 32-bit TDI signature compactor with split-word setup and masked compare.
// Assumes host writes seed/polynomial before strobing load and enabling shifts.
module tdi_sig_compactor #(
    parameter int SIG_W  = 32,
    parameter int WORD_W = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_wr,
    input  logic [$clog2(2*(SIG_W/WORD_W))-1:0]    cfg_sel,
    input  logic [WORD_W-1:0]                      cfg_wdata,
    input  logic                                   seed_load,
    input  logic                                   sig_en,
    input  logic                                   tdi_valid,
    input  logic                                   tdi_bit,
    output logic [WORD_W-1:0]                      sig_lo,
    output logic [WORD_W-1:0]                      sig_hi,
    input  logic                                   cmp_start,
    input  logic                                   cap_valid,
    input  logic [SIG_W-1:0]                       cap_word,
    input  logic [SIG_W-1:0]                       exp_word,
    input  logic [SIG_W-1:0]                       mask_word,
    input  logic                                   mask_en,
    output logic                                   cmp_pass
);
    logic [SIG_W-1:0] seed_w, poly_w, sig_w;

    sig_cfg_regs #(.SIG_W(SIG_W), .WORD_W(WORD_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
        .wdata(cfg_wdata), .seed(seed_w), .poly(poly_w)
    );

    sig_lfsr #(.SIG_W(SIG_W)) lfsr_i (
        .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_w),
        .poly(poly_w), .step(sig_en && tdi_valid), .din(tdi_bit),
        .state(sig_w)
    );

    sig_mask_cmp #(.SIG_W(SIG_W)) cmp_i (
        .clk(clk), .rst_n(rst_n), .start(cmp_start), .cap_valid(cap_valid),
        .cap_word(cap_word), .exp_word(exp_word), .mask_word(mask_word),
        .mask_en(mask_en), .pass(cmp_pass)
    );

    // Present the signature as two readback words.
    always_comb begin
        sig_lo = sig_w[WORD_W-1:0];
        sig_hi = sig_w[2*WORD_W-1:WORD_W];
    end

    // R1
    reset_fail_chk: assert property (@(posedge clk)
        !rst_n |=> (!cmp_pass && sig_lo == '0 && sig_hi == '0));
endmodule

// File: tb/tdi_sig_compactor_tb_top.sv
module tdi_sig_compactor_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, seed_load = 0, sig_en = 0, tdi_valid = 0, tdi_bit = 0;
    logic [1:0] cfg_sel = 0;
    logic [15:0] cfg_wdata = 0;
    logic cmp_start = 0, cap_valid = 0, mask_en = 0;
    logic [31:0] cap_word = 0, exp_word = 0, mask_word = 0;
    logic [15:0] sig_lo, sig_hi;
    logic cmp_pass;

    int n_run = 0, n_fail = 0;
    logic [31:0] m_seed = 0, m_poly = 0, m_sig = 0;
    logic m_pass = 0;

    always #4 clk = ~clk;

    tdi_sig_compactor dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .seed_load(seed_load), .sig_en(sig_en),
        .tdi_valid(tdi_valid), .tdi_bit(tdi_bit), .sig_lo(sig_lo), .sig_hi(sig_hi),
        .cmp_start(cmp_start), .cap_valid(cap_valid), .cap_word(cap_word),
        .exp_word(exp_word), .mask_word(mask_word), .mask_en(mask_en),
        .cmp_pass(cmp_pass)
    );

    function automatic logic [31:0] ref_step(logic [31:0] s, logic [31:0] p, logic d);
        logic [31:0] r;
        r = {s[30:0], 1'b0};
        if (s[31] != d) r = r ^ p;
        return r;
    endfunction

    function automatic logic ref_miss(logic [31:0] c, logic [31:0] e, logic [31:0] m, logic me);
        for (int i = 0; i < 32; i++)
            if (c[i] != e[i] && !(me && m[i])) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Clock one edge with the current inputs, update the model, check at negedge.
    task automatic tick(string tag);
        logic miss;
        @(posedge clk);
        miss = cap_valid && ref_miss(cap_word, exp_word, mask_word, mask_en);
        if (!rst_n) begin
            m_seed = 0; m_poly = 0; m_sig = 0; m_pass = 0;
        end else begin
            if (seed_load) m_sig = m_seed;
            else if (sig_en && tdi_valid) m_sig = ref_step(m_sig, m_poly, tdi_bit);
            if (cmp_start) m_pass = !miss;
            else if (miss) m_pass = 0;
            if (cfg_wr) case (cfg_sel)
                2'd0: m_seed[15:0] = cfg_wdata;
                2'd1: m_seed[31:16] = cfg_wdata;
                2'd2: m_poly[15:0] = cfg_wdata;
                default: m_poly[31:16] = cfg_wdata;
            endcase
        end
        @(negedge clk);
        check({tag, " R7 sig"}, {sig_hi, sig_lo}, m_sig);
        check({tag, " pass"}, {31'd0, cmp_pass}, {31'd0, m_pass});
        cfg_wr = 0; seed_load = 0; cmp_start = 0; cap_valid = 0; tdi_valid = 0;
    endtask

    task automatic wr(logic [1:0] s, logic [15:0] d);
        cfg_wr = 1; cfg_sel = s; cfg_wdata = d; tick("R2/R4 write");
    endtask

    initial begin
        #1_600_000;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        @(negedge clk);
        tick("R1 reset"); tick("R1 reset");
        rst_n = 1;
        tick("R1 idle");
        // R2: staging the seed leaves the signature alone
        wr(2'd0, 16'hBEEF); wr(2'd1, 16'hDEAD);
        check("R2 no load", {sig_hi, sig_lo}, 32'h0);
        // R3: load
        seed_load = 1; tick("R3 load");
        check("R3 seed", {sig_hi, sig_lo}, 32'hDEADBEEF);
        // R4: polynomial
        wr(2'd2, 16'h00B7); wr(2'd3, 16'h04C1);
        // R5: shifts
        for (int i = 0; i < 40; i++) begin
            sig_en = 1; tdi_valid = 1; tdi_bit = i[0] ^ i[2]; tick("R5 shift");
        end
        // R6: valid low or enable low
        sig_en = 0; tdi_valid = 1; tdi_bit = 1; tick("R6 en low");
        sig_en = 1; tdi_valid = 0; tick("R6 valid low");
        // R3 priority: load and shift together
        seed_load = 1; tdi_valid = 1; tdi_bit = 1; tick("R3 priority");
        check("R3 priority sig", {sig_hi, sig_lo}, 32'hDEADBEEF);
        // R8: start without word
        cmp_start = 1; tick("R8 arm");
        check("R8 pass", {31'd0, cmp_pass}, 32'd1);
        // R10: masked mismatch ignored
        cap_valid = 1; exp_word = 32'h12345678; cap_word = 32'h12345679;
        mask_word = 32'h1; mask_en = 1; tick("R10 masked");
        check("R10 masked keeps pass", {31'd0, cmp_pass}, 32'd1);
        // R10: mask disabled compares all
        cap_valid = 1; mask_en = 0; tick("R10 unmasked");
        check("R10 unmasked fails", {31'd0, cmp_pass}, 32'd0);
        // R9: sticky after matching word
        cap_valid = 1; cap_word = exp_word; tick("R9 sticky");
        check("R9 stays fail", {31'd0, cmp_pass}, 32'd0);
        // R11: start with mismatching word
        cmp_start = 1; cap_valid = 1; cap_word = 32'hFFFF0000; exp_word = 32'h0; tick("R11 start+miss");
        check("R11 fail", {31'd0, cmp_pass}, 32'd0);
        cmp_start = 1; cap_valid = 1; cap_word = exp_word; tick("R11 start+match");
        check("R11 pass", {31'd0, cmp_pass}, 32'd1);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] e;
            e = $urandom;
            cfg_wr = ($urandom_range(0, 15) == 0);
            cfg_sel = 2'($urandom); cfg_wdata = 16'($urandom);
            seed_load = ($urandom_range(0, 31) == 0);
            sig_en = ($urandom_range(0, 7) != 0);
            tdi_valid = ($urandom_range(0, 3) != 0);
            tdi_bit = 1'($urandom);
            cmp_start = ($urandom_range(0, 19) == 0);
            cap_valid = ($urandom_range(0, 1) == 0);
            exp_word = e;
            mask_word = $urandom; mask_en = 1'($urandom);
            cap_word = ($urandom_range(0, 9) == 0) ? (e ^ (32'h1 << $urandom_range(0, 31))) : e;
            tick("R5/R9 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule